// File: doc/BRIEF.md
# Memory-test read checker with failure logging

This block sits beside a memory self-test sequencer and judges every read that the sequencer issues. Each valid read is compared bit by bit against the value the test algorithm expected. The outcome is reported at two levels: a sticky pass/fail flag with a saturating count of mismatching reads, and, when diagnosis is selected, a small log of failing addresses. Each log entry carries the accumulated per-bit error mask for its address, so that a later redundancy-analysis step can decide whether a spare row or a spare column covers the faults.

After the run the log stays frozen until a clear. It is read one entry at a time by presenting an index, and the entry appears one clock later. A single-cycle clear returns every piece of state to its empty value, so the same checker can serve a sequence of runs or of memories.

Top module: `bist_fail_logger`

## Requirements
- R1: For each cycle with `rd_valid` high, the error mask is `rd_data ^ exp_data`; a non-zero mask is a mismatch. Cycles with `rd_valid` low have no effect, whatever the data.
- R2: A mismatch sets `fail_flag` two rising edges after the read is presented. The flag then stays set until `clr` or `rst`.
- R3: `diag_mode` is sampled together with each read. With it low (pass/fail level), a mismatch updates only the flag and the count and leaves the log empty. With it high (diagnosis level), the mismatch is also logged.
- R4: In diagnosis level, a mismatch at an address not yet in the log takes the next free entry. Entries fill from index 0 upward in order of detection, and each holds the address and the error mask. `log_used` gives the number of occupied entries.
- R5: A mismatch in diagnosis level at an address already in the log ORs its mask into that entry. It adds no entry, and this also applies when the log is full.
- R6: A mismatch in diagnosis level at a new address while all DEPTH entries are occupied is not stored, and it sets `log_ovf`, which stays set until a clear.
- R7: `fail_count` increments by one for every mismatching read at either level. It saturates at 2^CW-1.
- R8: A cycle with `clr` high zeroes the flag, the count, `log_ovf`, `log_used` and every entry at that edge. A read presented in the same cycle is discarded.
- R9: With `log_idx` applied, `log_entry_valid`, `log_addr` and `log_mask` show that entry after the next rising edge. An index at or beyond `log_used` reads as not valid. Entries keep their contents through idle cycles.
- R10: After a synchronous `rst`, the outputs equal the cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Single-cycle clear of all results |
| diag_mode | input | 1 | 0 = pass/fail level, 1 = diagnosis level |
| rd_valid | input | 1 | Read strobe from the test sequencer |
| rd_data | input | DW | Data returned by the memory |
| exp_data | input | DW | Value the algorithm expects |
| rd_addr | input | AW | Address of the read |
| log_idx | input | IW | Log entry to present |
| fail_flag | output | 1 | Sticky mismatch flag |
| fail_count | output | CW | Saturating mismatch count |
| log_ovf | output | 1 | A new failing address did not fit |
| log_used | output | UW | Occupied log entries |
| log_entry_valid | output | 1 | Presented entry is occupied |
| log_addr | output | AW | Address of the presented entry |
| log_mask | output | DW | Accumulated error mask of the presented entry |

## Verification
The bench drives repeated failures at one address with disjoint bits. A checker that appended instead of merging would show a grown `log_used` and two half masks. It fills the log and then adds one more new address and one known address. A wrong full test would either overwrite entry 0 or raise the overflow flag on the merge. It pushes the count past its ceiling, which a wrapping counter would show as a small value, and it asserts a failing read together with clear, which a clear without priority would let through as a count of one. Mismatching data with the strobe low and failures in pass/fail level must leave the count or the log untouched.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

  // Reporting level selected per read.
  typedef enum logic {
    LVL_GONOGO = 1'b0,
    LVL_DIAG   = 1'b1
  } level_e;

endpackage

// File: rtl/fcap_cmp.sv
// Compare stage: registers the bitwise error mask of each strobed read.
module fcap_cmp
  import fcap_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] in_exp,
  input  logic [AW-1:0] in_addr,
  input  level_e        in_level,
  output logic          st_miss,
  output logic [DW-1:0] st_mask,
  output logic [AW-1:0] st_addr,
  output level_e        st_level
);

  logic [DW-1:0] diff;

  assign diff = in_data ^ in_exp;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st_miss  <= 1'b0;
      st_mask  <= '0;
      st_addr  <= '0;
      st_level <= LVL_GONOGO;
    end else begin
      st_miss  <= in_valid && (|diff);
      st_mask  <= in_valid ? diff : '0;
      st_addr  <= in_addr;
      st_level <= in_level;
    end
  end

endmodule

// File: rtl/fcap_tally.sv
// Sticky pass/fail flag and saturating mismatch counter.
module fcap_tally #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          miss,
  output logic          flag,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag  <= 1'b0;
      count <= '0;
    end else if (miss) begin
      flag <= 1'b1;
      if (count != CMAX) begin
        count <= count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fcap_log.sv
// Failure log: address-matched merge, in-order fill, overflow, indexed read.
module fcap_log #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int UW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_mask,
  input  logic [IW-1:0] rd_idx,
  output logic [UW-1:0] used,
  output logic          ovf,
  output logic          q_valid,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_mask
);

  logic [AW-1:0]    ent_addr [DEPTH];
  logic [DW-1:0]    ent_mask [DEPTH];
  logic [DEPTH-1:0] hit;
  logic             full;

  // One address comparator per entry; only occupied entries may match.
  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit[g] = (UW'(g) < used) && (ent_addr[g] == wr_addr);
  end

  assign full = (used == UW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      used <= '0;
      ovf  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_addr[i] <= '0;
        ent_mask[i] <= '0;
      end
    end else if (wr_en) begin
      if (|hit) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (hit[i]) begin
            ent_mask[i] <= ent_mask[i] | wr_mask;
          end
        end
      end else if (!full) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (UW'(i) == used) begin
            ent_addr[i] <= wr_addr;
            ent_mask[i] <= wr_mask;
          end
        end
        used <= used + 1'b1;
      end else begin
        ovf <= 1'b1;
      end
    end
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_addr  <= '0;
      q_mask  <= '0;
    end else begin
      q_valid <= int'(rd_idx) < int'(used);
      if (int'(rd_idx) < DEPTH) begin
        q_addr <= ent_addr[rd_idx];
        q_mask <= ent_mask[rd_idx];
      end else begin
        q_addr <= '0;
        q_mask <= '0;
      end
    end
  end

endmodule

// File: rtl/bist_fail_logger.sv
module bist_fail_logger
  import fcap_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 12,
  parameter int DEPTH = 8,
  parameter int CW    = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int UW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          diag_mode,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] exp_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [IW-1:0] log_idx,
  output logic          fail_flag,
  output logic [CW-1:0] fail_count,
  output logic          log_ovf,
  output logic [UW-1:0] log_used,
  output logic          log_entry_valid,
  output logic [AW-1:0] log_addr,
  output logic [DW-1:0] log_mask
);

  logic          st_miss;
  logic [DW-1:0] st_mask;
  logic [AW-1:0] st_addr;
  level_e        st_level;
  logic          log_wr;

  fcap_cmp #(.DW(DW), .AW(AW)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .in_valid (rd_valid),
    .in_data  (rd_data),
    .in_exp   (exp_data),
    .in_addr  (rd_addr),
    .in_level (level_e'(diag_mode)),
    .st_miss  (st_miss),
    .st_mask  (st_mask),
    .st_addr  (st_addr),
    .st_level (st_level)
  );

  fcap_tally #(.CW(CW)) u_tally (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .miss  (st_miss),
    .flag  (fail_flag),
    .count (fail_count)
  );

  assign log_wr = st_miss && (st_level == LVL_DIAG);

  fcap_log #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_log (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .wr_en   (log_wr),
    .wr_addr (st_addr),
    .wr_mask (st_mask),
    .rd_idx  (log_idx),
    .used    (log_used),
    .ovf     (log_ovf),
    .q_valid (log_entry_valid),
    .q_addr  (log_addr),
    .q_mask  (log_mask)
  );

endmodule

// File: rtl/fcap_checker.sv
module fcap_checker #(
  parameter int DEPTH = 8,
  parameter int CW    = 8,
  parameter int UW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic          fail_flag,
  input logic [CW-1:0] fail_count,
  input logic          log_ovf,
  input logic [UW-1:0] log_used
);

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  a_r2_flag_holds: assert property (@(posedge clk) disable iff (rst)
    fail_flag && !clr |=> fail_flag);

  a_r2_count_implies_flag: assert property (@(posedge clk) disable iff (rst)
    fail_count != '0 |-> fail_flag);

  a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr |=> !fail_flag && fail_count == '0 && !log_ovf && log_used == '0);

  a_r6_ovf_only_full: assert property (@(posedge clk) disable iff (rst)
    log_ovf |-> log_used == UW'(DEPTH));

  a_r7_count_saturates: assert property (@(posedge clk) disable iff (rst)
    (fail_count == CMAX) && !clr |=> fail_count == CMAX);

  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (fail_count == $past(fail_count)) ||
             (fail_count == $past(fail_count) + 1'b1));

  a_r4_used_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (log_used == $past(log_used)) ||
             (log_used == $past(log_used) + 1'b1));

endmodule

bind bist_fail_logger fcap_checker #(.DEPTH(DEPTH), .CW(CW), .UW(UW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr        (clr),
  .fail_flag  (fail_flag),
  .fail_count (fail_count),
  .log_ovf    (log_ovf),
  .log_used   (log_used)
);

// File: tb/bist_fail_logger_test.sv
module bist_fail_logger_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int AW    = 8;
  localparam int DEPTH = 4;
  localparam int CW    = 4;
  localparam int IW    = 2;
  localparam int UW    = 3;
  localparam int CMAX  = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr = 1'b0;
  logic          diag_mode = 1'b0;
  logic          rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic [DW-1:0] exp_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [IW-1:0] log_idx = '0;
  logic          fail_flag;
  logic [CW-1:0] fail_count;
  logic          log_ovf;
  logic [UW-1:0] log_used;
  logic          log_entry_valid;
  logic [AW-1:0] log_addr;
  logic [DW-1:0] log_mask;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bist_fail_logger #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .CW(CW)) uut (
    .clk(clk), .rst(rst), .clr(clr), .diag_mode(diag_mode),
    .rd_valid(rd_valid), .rd_data(rd_data), .exp_data(exp_data),
    .rd_addr(rd_addr), .log_idx(log_idx), .fail_flag(fail_flag),
    .fail_count(fail_count), .log_ovf(log_ovf), .log_used(log_used),
    .log_entry_valid(log_entry_valid), .log_addr(log_addr), .log_mask(log_mask)
  );

  typedef struct {
    bit            valid;
    logic [AW-1:0] addr;
    logic [DW-1:0] mask;
  } item_t;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model built from the requirements.
  logic [AW-1:0] m_addr [$];
  logic [DW-1:0] m_mask [$];
  int            m_cnt;
  bit            m_flag;
  bit            m_ovf;
  item_t         exp_q [$];

  task automatic chk(string req, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic model_clear();
    m_addr.delete();
    m_mask.delete();
    m_cnt  = 0;
    m_flag = 0;
    m_ovf  = 0;
  endtask

  task automatic model_read(logic [AW-1:0] a, logic [DW-1:0] d,
                            logic [DW-1:0] e, bit mode);
    logic [DW-1:0] mk;
    bit found;
    mk = d ^ e;
    if (mk != '0) begin
      if (m_cnt < CMAX) m_cnt++;
      m_flag = 1;
      if (mode) begin
        found = 0;
        foreach (m_addr[k]) begin
          if (m_addr[k] == a) begin
            m_mask[k] = m_mask[k] | mk;
            found = 1;
          end
        end
        if (!found) begin
          if (m_addr.size() < DEPTH) begin
            m_addr.push_back(a);
            m_mask.push_back(mk);
          end else begin
            m_ovf = 1;
          end
        end
      end
    end
  endtask

  // Driver: one strobed read per cycle, called at a falling edge.
  task automatic do_read(logic [AW-1:0] a, logic [DW-1:0] d,
                         logic [DW-1:0] e, bit mode);
    rd_valid  = 1'b1;
    rd_addr   = a;
    rd_data   = d;
    exp_data  = e;
    diag_mode = mode;
    @(negedge clk);
    rd_valid = 1'b0;
    model_read(a, d, e, mode);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_clear();
  endtask

  task automatic check_status(string req);
    chk(req, "fail_flag", fail_flag, m_flag);
    chk(req, "fail_count", fail_count, m_cnt);
    chk(req, "log_ovf", log_ovf, m_ovf);
    chk(req, "log_used", log_used, m_addr.size());
  endtask

  // Scoreboard: push expected entries, then pop as the read port answers.
  task automatic check_log(string req);
    item_t it;
    item_t got;
    for (int i = 0; i < DEPTH; i++) begin
      it.valid = (i < m_addr.size());
      it.addr  = it.valid ? m_addr[i] : '0;
      it.mask  = it.valid ? m_mask[i] : '0;
      exp_q.push_back(it);
    end
    for (int i = 0; i < DEPTH; i++) begin
      log_idx = IW'(i);
      @(negedge clk);
      got.valid = log_entry_valid;
      got.addr  = log_addr;
      got.mask  = log_mask;
      it = exp_q.pop_front();
      chk(req, $sformatf("entry %0d valid", i), got.valid, it.valid);
      if (it.valid) begin
        chk(req, $sformatf("entry %0d addr", i), got.addr, it.addr);
        chk(req, $sformatf("entry %0d mask", i), got.mask, it.mask);
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    check_status("R10");
    check_log("R10");

    // R1: matching reads of several patterns leave everything clear
    do_read(8'h01, 16'h0000, 16'h0000, 1'b1);
    do_read(8'h02, 16'hFFFF, 16'hFFFF, 1'b1);
    do_read(8'h03, 16'h5555, 16'h5555, 1'b0);
    do_read(8'h04, 16'hAAAA, 16'hAAAA, 1'b1);
    settle();
    check_status("R1");

    // R1: strobe low with differing data is ignored
    rd_data  = 16'h1234;
    exp_data = 16'h0000;
    diag_mode = 1'b1;
    repeat (4) @(negedge clk);
    settle();
    check_status("R1");

    // R3, R2: pass/fail level mismatch sets flag only
    do_read(8'h10, 16'h0004, 16'h0000, 1'b0);
    settle();
    check_status("R3");
    check_log("R3");
    for (int i = 0; i < 5; i++) do_read(8'(i), 16'h00FF, 16'h00FF, 1'b0);
    settle();
    chk("R2", "flag sticky", fail_flag, 1);

    // R8: clear
    do_clear();
    settle();
    check_status("R8");

    // R4: diagnosis logging in order
    do_read(8'h05, 16'h00F0, 16'h00F0, 1'b1);
    do_read(8'h05, 16'h0001, 16'h0000, 1'b1);
    do_read(8'h09, 16'hFFFF, 16'hFF7F, 1'b1);
    settle();
    check_status("R4");
    check_log("R4");

    // R5: repeated address merges its mask
    do_read(8'h05, 16'h0000, 16'h8000, 1'b1);
    settle();
    check_status("R5");
    check_log("R5");

    // R6: fill the log, then overflow; merge still works when full
    do_read(8'h20, 16'h0010, 16'h0000, 1'b1);
    do_read(8'h21, 16'h0000, 16'h0020, 1'b1);
    settle();
    chk("R6", "ovf before full", log_ovf, 0);
    do_read(8'h09, 16'h0100, 16'h0000, 1'b1);
    settle();
    chk("R5", "merge when full no ovf", log_ovf, 0);
    do_read(8'h22, 16'h0003, 16'h0000, 1'b1);
    settle();
    check_status("R6");
    check_log("R6");

    // R9: contents held through idle cycles
    repeat (10) @(negedge clk);
    check_log("R9");

    // R7: count saturation in pass/fail level
    do_clear();
    for (int i = 0; i < 20; i++) do_read(8'(i), 16'h0001, 16'h0002, 1'b0);
    settle();
    check_status("R7");
    chk("R7", "saturated count", fail_count, CMAX);

    // R8: read coincident with clear is discarded
    clr       = 1'b1;
    rd_valid  = 1'b1;
    rd_addr   = 8'h33;
    rd_data   = 16'hFFFF;
    exp_data  = 16'h0000;
    diag_mode = 1'b1;
    @(negedge clk);
    clr      = 1'b0;
    rd_valid = 1'b0;
    model_clear();
    settle();
    check_status("R8");
    check_log("R8");

    summary();
  end

endmodule